// File: doc/BRIEF.md
# Predicated Vector Compare Sequencer

This block takes a compare-and-branch operation and checks whether either source register has been tagged as a vector. If so, it does not branch. Instead it walks the active vector length one element per cycle and compares a pair of register-file values on each step. It collects the outcomes into a mask that is one bit per element and at most XLEN bits wide. When the walk ends, the mask is written to a predicate register. That register is named by the field the branch would otherwise use as its offset. When neither source is a vector, the block raises a one-cycle fall-through pulse and the ordinary scalar branch unit handles the operation.

Each source is treated independently. A vector source reads register `idx + i` for element `i`, and the index wraps modulo the register count. A scalar source is read from the same register on every step. The comparisons are signed integer compares: equal, less-than and less-or-equal. Software gets greater-than and greater-or-equal by swapping the two sources. A pulse on `start_i` launches an operation. The single-cycle `done_o` pulse, which comes together with the predicate write, ends it.

Top module: `vcmp_seq`

## Requirements
- R1: When `start_i` is seen while idle and neither `src1_vec_i` nor `src2_vec_i` is set, `scalar_br_o` is high for exactly the next cycle. No predicate write and no `done_o` are produced.
- R2: For element i, a vector source is read at index (idx + i) mod NREG. A scalar source is read at its idx for every element.
- R3: Bit i of the written mask is 1 exactly when the compare for element i is true. Every bit at position VL or above is 0, because the mask starts cleared.
- R4: funct3 3'b010 selects equality, 3'b001 selects signed less-than and 3'b000 selects signed less-or-equal.
- R5: With a vector source, any other funct3 value (including the reserved 3'b011) makes `illegal_o` high for one cycle. No predicate write and no `done_o` follow.
- R6: `done_o` and `pred_we_o` are high together for one cycle. That cycle is VL clock edges after the start edge. `pred_addr_o` carries the target index captured at start.
- R7: VL values above XLEN are treated as XLEN. VL = 0 gives `done_o` in the cycle right after start, with a zero mask.
- R8: `start_i` has no effect while `busy_o` is high. The operation in flight finishes with its own operands, target and length.
- R9: Less-than with the two sources swapped yields the greater-than mask of the original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| funct3_i | input | 3 | Compare selector |
| src1_idx_i | input | IDX_W | First source register index |
| src1_vec_i | input | 1 | First source tagged as vector |
| src2_idx_i | input | IDX_W | Second source register index |
| src2_vec_i | input | 1 | Second source tagged as vector |
| pred_idx_i | input | IDX_W | Predicate target index (from the branch offset field) |
| vl_i | input | VL_W | Active vector length |
| rf_addr1_o | output | IDX_W | Read address, first operand |
| rf_data1_i | input | XLEN | Read data, first operand (same cycle) |
| rf_addr2_o | output | IDX_W | Read address, second operand |
| rf_data2_i | input | XLEN | Read data, second operand (same cycle) |
| pred_we_o | output | 1 | Predicate register write strobe |
| pred_addr_o | output | IDX_W | Predicate register index |
| pred_data_o | output | XLEN | Predicate mask |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Mask complete |
| scalar_br_o | output | 1 | Fall-through to the scalar branch |
| illegal_o | output | 1 | Reserved compare code with a vector source |

## Verification
The assertions check the following on every cycle:
- The completion, fall-through and illegal pulses never overlap.
- An idle start with two scalar sources always falls through.
- Between consecutive elements, each read address steps by one or holds still, according to its vector tag.
- The written mask never has a bit set at or above the captured length.

Only the bench scenarios can show the rest:
- The mask values for each compare code.
- The exact completion cycle for several lengths, including zero and the clamp.
- Index wrap-around past the last register.
- The swapped-source greater-than result.
- That a start arriving mid-run leaves the result untouched.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    CMP_LE = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2
  } cmp_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN,
    ST_FALL,
    ST_ILL
  } seq_st_e;
endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
  import vcmp_pkg::*;
(
  input  logic [2:0] funct3_i,
  output cmp_op_e    op_o,
  output logic       bad_o
);
  always_comb begin
    op_o  = CMP_EQ;
    bad_o = 1'b0;
    unique case (funct3_i)
      3'b000:  op_o = CMP_LE;
      3'b001:  op_o = CMP_LT;
      3'b010:  op_o = CMP_EQ;
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/vcmp_elem.sv
module vcmp_elem
  import vcmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cmp_op_e           op_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              hit_o
);
  logic eq, lt;
  assign eq = (a_i == b_i);
  assign lt = ($signed(a_i) < $signed(b_i));

  always_comb begin
    unique case (op_i)
      CMP_LE:  hit_o = lt | eq;
      CMP_LT:  hit_o = lt;
      default: hit_o = eq;
    endcase
  end
endmodule

// File: rtl/vcmp_seq.sv
module vcmp_seq
  import vcmp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W  = $clog2(XLEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       funct3_i,
  input  logic [IDX_W-1:0] src1_idx_i,
  input  logic             src1_vec_i,
  input  logic [IDX_W-1:0] src2_idx_i,
  input  logic             src2_vec_i,
  input  logic [IDX_W-1:0] pred_idx_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic [IDX_W-1:0] rf_addr1_o,
  input  logic [XLEN-1:0]  rf_data1_i,
  output logic [IDX_W-1:0] rf_addr2_o,
  input  logic [XLEN-1:0]  rf_data2_i,
  output logic             pred_we_o,
  output logic [IDX_W-1:0] pred_addr_o,
  output logic [XLEN-1:0]  pred_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             scalar_br_o,
  output logic             illegal_o
);
  seq_st_e          st_q;
  cmp_op_e          op_d, op_q;
  logic             bad_d, hit, accept, run_w;
  logic [IDX_W-1:0] pred_q;
  logic [VL_W-1:0]  vl_eff, vl_q, cnt_q;
  logic [XLEN-1:0]  mask_q;

  logic [IDX_W-1:0] src_in [2];
  logic             vec_in [2];
  logic [IDX_W-1:0] addr_w [2];
  logic             vec_w  [2];

  assign src_in[0] = src1_idx_i;
  assign src_in[1] = src2_idx_i;
  assign vec_in[0] = src1_vec_i;
  assign vec_in[1] = src2_vec_i;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign run_w  = (st_q == ST_RUN);
  assign vl_eff = (vl_i > VL_W'(XLEN)) ? VL_W'(XLEN) : vl_i;

  vcmp_decode u_dec (
    .funct3_i (funct3_i),
    .op_o     (op_d),
    .bad_o    (bad_d)
  );

  // per-operand index capture and element stepping
  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [IDX_W-1:0] src_q;
    logic             vec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q <= '0;
        vec_q <= 1'b0;
      end else if (accept) begin
        src_q <= src_in[k];
        vec_q <= vec_in[k];
      end
    end
    assign addr_w[k] = vec_q ? src_q + IDX_W'(cnt_q) : src_q;
    assign vec_w[k]  = vec_q;
  end

  vcmp_elem #(.XLEN(XLEN)) u_elem (
    .op_i  (op_q),
    .a_i   (rf_data1_i),
    .b_i   (rf_data2_i),
    .hit_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= CMP_EQ;
      pred_q <= '0;
      vl_q   <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          op_q   <= op_d;
          pred_q <= pred_idx_i;
          vl_q   <= vl_eff;
          cnt_q  <= '0;
          mask_q <= '0;
          if (!src1_vec_i && !src2_vec_i) st_q <= ST_FALL;
          else if (bad_d)                 st_q <= ST_ILL;
          else if (vl_eff == '0)          st_q <= ST_FIN;
          else                            st_q <= ST_RUN;
        end
        ST_RUN: begin
          mask_q <= mask_q | (XLEN'(hit) << cnt_q);
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == vl_q - 1'b1) st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_addr1_o  = addr_w[0];
  assign rf_addr2_o  = addr_w[1];
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign pred_we_o   = (st_q == ST_FIN);
  assign pred_addr_o = pred_q;
  assign pred_data_o = mask_q;
  assign scalar_br_o = (st_q == ST_FALL);
  assign illegal_o   = (st_q == ST_ILL);
endmodule

// File: rtl/vcmp_seq_chk.sv
module vcmp_seq_chk #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W  = $clog2(XLEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             src1_vec_i,
  input logic             src2_vec_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             pred_we_o,
  input logic             scalar_br_o,
  input logic             illegal_o,
  input logic [IDX_W-1:0] rf_addr1_o,
  input logic [IDX_W-1:0] rf_addr2_o,
  input logic [XLEN-1:0]  pred_data_o,
  input logic             run_i,
  input logic             vec_i [2],
  input logic [VL_W-1:0]  vl_i
);
  p_pulse_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, scalar_br_o, illegal_o}));

  p_done_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !src1_vec_i && !src2_vec_i |=> scalar_br_o && !pred_we_o);

  p_ill_nowrite_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !pred_we_o ##1 !busy_o);

  p_step1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && vec_i[0] |-> rf_addr1_o == IDX_W'($past(rf_addr1_o) + 1'b1));

  p_step2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && vec_i[1] |-> rf_addr2_o == IDX_W'($past(rf_addr2_o) + 1'b1));

  p_hold1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !vec_i[0] |-> $stable(rf_addr1_o));

  p_hold2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !vec_i[1] |-> $stable(rf_addr2_o));

  p_mask_clean_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (vl_i < VL_W'(XLEN)) |-> (pred_data_o >> vl_i) == '0);
endmodule

bind vcmp_seq vcmp_seq_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .src1_vec_i  (src1_vec_i),
  .src2_vec_i  (src2_vec_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pred_we_o   (pred_we_o),
  .scalar_br_o (scalar_br_o),
  .illegal_o   (illegal_o),
  .rf_addr1_o  (rf_addr1_o),
  .rf_addr2_o  (rf_addr2_o),
  .pred_data_o (pred_data_o),
  .run_i       (run_w),
  .vec_i       (vec_w),
  .vl_i        (vl_q)
);

// File: tb/vcmp_seq_test.sv
module vcmp_seq_test;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int IDX_W = $clog2(NREG);
  localparam int VL_W = $clog2(XLEN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] f3 = 3'b010;
  logic [IDX_W-1:0] s1 = '0, s2 = '0, pidx = '0;
  logic v1 = 1'b0, v2 = 1'b0;
  logic [VL_W-1:0] vl = '0;
  logic [IDX_W-1:0] a1, a2, paddr;
  logic [XLEN-1:0] d1, d2, pdata;
  logic pwe, busy, done, sbr, ill;
  logic [XLEN-1:0] rf [NREG];

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign d1 = rf[a1];
  assign d2 = rf[a2];

  vcmp_seq #(.XLEN(XLEN), .NREG(NREG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .funct3_i(f3),
    .src1_idx_i(s1), .src1_vec_i(v1), .src2_idx_i(s2), .src2_vec_i(v2),
    .pred_idx_i(pidx), .vl_i(vl),
    .rf_addr1_o(a1), .rf_data1_i(d1), .rf_addr2_o(a2), .rf_data2_i(d2),
    .pred_we_o(pwe), .pred_addr_o(paddr), .pred_data_o(pdata),
    .busy_o(busy), .done_o(done), .scalar_br_o(sbr), .illegal_o(ill)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [XLEN-1:0] model(input logic [2:0] fc, input int i1, input bit w1,
                                            input int i2, input bit w2, input int len);
    logic [XLEN-1:0] m = '0;
    int n = (len > XLEN) ? XLEN : len;
    for (int i = 0; i < n; i++) begin
      logic [XLEN-1:0] a = rf[w1 ? (i1 + i) % NREG : i1];
      logic [XLEN-1:0] b = rf[w2 ? (i2 + i) % NREG : i2];
      bit h;
      case (fc)
        3'b010:  h = (a == b);
        3'b001:  h = ($signed(a) < $signed(b));
        default: h = ($signed(a) <= $signed(b));
      endcase
      m[i] = h;
    end
    return m;
  endfunction

  task automatic launch(input logic [2:0] fc, input int i1, input bit w1, input int i2,
                        input bit w2, input int p, input int len);
    f3 = fc; s1 = IDX_W'(i1); v1 = w1; s2 = IDX_W'(i2); v2 = w2;
    pidx = IDX_W'(p); vl = VL_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  // full vector run with mask, timing and target checks
  task automatic t_vec(input string req, input logic [2:0] fc, input int i1, input bit w1,
                       input int i2, input bit w2, input int p, input int len);
    int n;
    int eff = (len > XLEN) ? XLEN : len;
    logic [XLEN-1:0] exp = model(fc, i1, w1, i2, w2, len);
    launch(fc, i1, w1, i2, w2, p, len);
    wait_done(n);
    check({req, " done cycle (R6)"}, XLEN'(n), XLEN'(eff));
    check({req, " write strobe (R6)"}, XLEN'(pwe), 1);
    check({req, " target index (R6)"}, XLEN'(paddr), XLEN'(p));
    check({req, " mask (R3)"}, pdata, exp);
    @(negedge clk);
    check({req, " single pulse (R6)"}, XLEN'({busy, done, pwe}), 0);
  endtask

  task automatic t_reset;
    check("R6 reset quiet", XLEN'({busy, done, pwe, sbr, ill}), 0);
  endtask

  task automatic t_scalar;
    launch(3'b010, 3, 1'b0, 4, 1'b0, 7, 8);
    check("R1 fall-through pulse", XLEN'(sbr), 1);
    check("R1 no write/done", XLEN'({pwe, done}), 0);
    @(negedge clk);
    check("R1 pulse one cycle", XLEN'({sbr, busy}), 0);
  endtask

  task automatic t_illegal(input logic [2:0] fc);
    launch(fc, 2, 1'b1, 5, 1'b0, 9, 6);
    check("R5 illegal flag", XLEN'(ill), 1);
    check("R5 no write/done", XLEN'({pwe, done}), 0);
    @(negedge clk);
    check("R5 flag one cycle, idle", XLEN'({ill, busy, pwe}), 0);
  endtask

  task automatic t_swap;
    int n;
    logic [XLEN-1:0] gt = '0;
    for (int i = 0; i < 12; i++)
      gt[i] = ($signed(rf[(4 + i) % NREG]) > $signed(rf[20]));
    launch(3'b001, 20, 1'b0, 4, 1'b1, 11, 12);
    wait_done(n);
    check("R9 swapped lt gives gt", pdata, gt);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    int n;
    logic [XLEN-1:0] exp = model(3'b000, 1, 1'b1, 9, 1'b1, 10);
    launch(3'b000, 1, 1'b1, 9, 1'b1, 13, 10);
    @(negedge clk);
    @(negedge clk);
    f3 = 3'b010; s1 = 5'd17; v1 = 1'b0; s2 = 5'd22; v2 = 1'b0;
    pidx = 5'd2; vl = 6'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    check("R8 length kept", XLEN'(n + 3), 10);
    check("R8 target kept", XLEN'(paddr), 13);
    check("R8 mask kept", pdata, exp);
    @(negedge clk);
    check("R8 no second op", XLEN'({busy, sbr, ill}), 0);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) rf[k] = XLEN'(((k * 37) % 13) - 6);
    rf[8] = rf[24];
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scalar();
    t_vec("R4 eq vec-vec", 3'b010, 0, 1'b1, 16, 1'b1, 5, 16);
    t_vec("R4 lt vec-scalar", 3'b001, 3, 1'b1, 7, 1'b0, 6, 20);
    t_vec("R4 le scalar-vec", 3'b000, 12, 1'b0, 0, 1'b1, 1, 32);
    t_vec("R2 index wrap", 3'b001, 29, 1'b1, 30, 1'b0, 3, 6);
    t_vec("R7 vl zero", 3'b010, 4, 1'b1, 4, 1'b1, 10, 0);
    t_vec("R7 vl clamp", 3'b000, 0, 1'b1, 0, 1'b1, 12, 40);
    t_vec("R3 single element", 3'b010, 8, 1'b0, 24, 1'b1, 14, 1);
    t_illegal(3'b011);
    t_illegal(3'b110);
    t_swap();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule